// File: doc/BRIEF.md
# State-Restore Fault Arbiter

This block decides, before a floating-point/SIMD state-restore instruction runs, which fault that instruction must take, if any. A decode stage pulses a request strobe together with the instruction's context: the operand address, real or protected mode, privilege level, the emulation, task-switched and alignment-mask control bits, the flags-register alignment bit, a lock-prefix indicator, the segment in use and a segment-limit violation flag.

One cycle after the strobe the block presents a fault code with a single-cycle valid pulse. Several fault sources can be active at once, so the block resolves them in a fixed priority order. A lock prefix ranks highest, then device-not-available, then segment and range faults, then alignment faults.

The alignment verdict is the most involved part. The operand must sit on a 16-byte boundary. A misaligned operand normally takes a general-protection fault. An alignment-check fault is taken instead only when alignment checking is fully enabled and the misalignment is at the finest (odd-byte) granularity.

Top module: `restore_fault_chk`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `fault_vld`=0 and `fault_code`=0.
- R2: A request with `lock_pfx`=1 yields code 1 (invalid opcode), whatever the other inputs are.
- R3: A request without a lock prefix and with `cr_em`=1 or `cr_ts`=1 yields code 2 (device not available).
- R4: In protected mode (`prot_mode`=1), with no higher fault, `lim_viol`=1 with `seg_sel`=2 (the stack segment) yields code 4 (stack fault).
- R5: In protected mode, with no higher fault, `lim_viol`=1 with any `seg_sel` other than 2 yields code 3 (general protection).
- R6: In real mode (`prot_mode`=0), with no higher fault, an operand whose last byte (`addr`+511) lies above 0xFFFF yields code 6 (interrupt 13). A misaligned operand in real mode also yields code 6. In real mode `lim_viol`, `cpl`, `cr_am` and `eflag_ac` have no effect.
- R7: In protected mode, with no higher fault and alignment checking not enabled, an address with any of bits [3:0] set yields code 3.
- R8: Alignment checking is enabled only when `cr_am`=1, `eflag_ac`=1 and `cpl`=3. With it enabled, a misaligned address with `addr[0]`=1 yields code 5 (alignment check).
- R9: With alignment checking enabled, an address with `addr[0]`=0 but any of bits [3:1] set yields code 3.
- R10: A request with no fault condition (aligned, in range, no violation, no prefix, clear control bits) yields code 0.
- R11: `fault_vld` is high in exactly the cycle after each cycle with `req`=1. `fault_code` changes only in the cycle after a request and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; the context is sampled in this cycle |
| addr | input | 32 | Operand effective address |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| cpl | input | 2 | Current privilege level |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_am | input | 1 | Alignment-mask control bit |
| eflag_ac | input | 1 | Flags-register alignment-check bit |
| lock_pfx | input | 1 | Instruction carries a lock prefix |
| seg_sel | input | 3 | Segment in use; 2 means the stack segment |
| lim_viol | input | 1 | Operand violates the segment limit |
| fault_vld | output | 1 | One-cycle pulse, the cycle after `req` |
| fault_code | output | 3 | 0 none, 1 UD, 2 NM, 3 GP, 4 SS, 5 AC, 6 real-mode int 13 |

## Verification
A wrong priority or a wrong alignment-enable term shows on `fault_code` in the cycle right after the offending request. No state carries over between requests apart from the held code, so every error is visible within one cycle and cannot hide behind later traffic. A broken hold or pulse register shows as a code that changes or a valid that rises in a cycle with no request before it. The bench compares both outputs against its model on every cycle, including idle ones.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_SS   = 3'd4,
        FLT_AC   = 3'd5,
        FLT_RM13 = 3'd6
    } fault_e;

    localparam logic [2:0] SEG_STACK = 3'd2;

    typedef struct packed {
        logic   hit;
        fault_e code;
    } verdict_t;

    localparam verdict_t NO_VERDICT = '{hit: 1'b0, code: FLT_NONE};

    // Higher-priority verdict wins when it hits.
    function automatic verdict_t pick(input verdict_t hi, input verdict_t lo);
        return hi.hit ? hi : lo;
    endfunction

endpackage

// File: rtl/rfc_early_eval.sv
module rfc_early_eval
    import rfc_pkg::*;
(
    input  logic     lock_pfx,
    input  logic     cr_em,
    input  logic     cr_ts,
    output verdict_t verdict
);
    always_comb begin
        verdict = NO_VERDICT;
        if (lock_pfx) begin
            verdict.hit  = 1'b1;
            verdict.code = FLT_UD;
        end else if (cr_em || cr_ts) begin
            verdict.hit  = 1'b1;
            verdict.code = FLT_NM;
        end
    end
endmodule

// File: rtl/rfc_seg_eval.sv
module rfc_seg_eval
    import rfc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IMAGE_BYTES = 512,
    parameter int RM_LIMIT    = 65535
) (
    input  logic              prot_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        seg_sel,
    input  logic              lim_viol,
    output verdict_t          verdict
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] last_byte;
    logic             past_limit;

    assign last_byte  = {1'b0, addr} + EXT_W'(IMAGE_BYTES - 1);
    assign past_limit = last_byte > EXT_W'(RM_LIMIT);

    always_comb begin
        verdict = NO_VERDICT;
        if (!prot_mode) begin
            if (past_limit) begin
                verdict.hit  = 1'b1;
                verdict.code = FLT_RM13;
            end
        end else if (lim_viol) begin
            verdict.hit  = 1'b1;
            verdict.code = (seg_sel == SEG_STACK) ? FLT_SS : FLT_GP;
        end
    end
endmodule

// File: rtl/rfc_align_eval.sv
module rfc_align_eval
    import rfc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int ALIGN_LOG2   = 4,
    parameter int AC_GRAN_LOG2 = 1
) (
    input  logic              prot_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cpl,
    input  logic              cr_am,
    input  logic              eflag_ac,
    output verdict_t          verdict
);
    logic misaligned;
    logic fine_miss;
    logic ac_enabled;

    assign misaligned = |addr[ALIGN_LOG2-1:0];
    assign ac_enabled = prot_mode && cr_am && eflag_ac && (cpl == 2'd3);

    generate
        if (AC_GRAN_LOG2 > 0) begin : g_fine
            assign fine_miss = |addr[AC_GRAN_LOG2-1:0];
        end else begin : g_nofine
            assign fine_miss = 1'b0;
        end
    endgenerate

    always_comb begin
        verdict = NO_VERDICT;
        if (misaligned) begin
            verdict.hit = 1'b1;
            if (!prot_mode)
                verdict.code = FLT_RM13;
            else if (ac_enabled && fine_miss)
                verdict.code = FLT_AC;
            else
                verdict.code = FLT_GP;
        end
    end
endmodule

// File: rtl/restore_fault_chk.sv
module restore_fault_chk
    import rfc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int IMAGE_BYTES  = 512,
    parameter int RM_LIMIT     = 65535,
    parameter int ALIGN_LOG2   = 4,
    parameter int AC_GRAN_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_mode,
    input  logic [1:0]        cpl,
    input  logic              cr_em,
    input  logic              cr_ts,
    input  logic              cr_am,
    input  logic              eflag_ac,
    input  logic              lock_pfx,
    input  logic [2:0]        seg_sel,
    input  logic              lim_viol,
    output logic              fault_vld,
    output logic [2:0]        fault_code
);
    verdict_t v_early, v_seg, v_align, v_final;
    fault_e   code_q;

    rfc_early_eval u_early (
        .lock_pfx (lock_pfx),
        .cr_em    (cr_em),
        .cr_ts    (cr_ts),
        .verdict  (v_early)
    );

    rfc_seg_eval #(
        .ADDR_W      (ADDR_W),
        .IMAGE_BYTES (IMAGE_BYTES),
        .RM_LIMIT    (RM_LIMIT)
    ) u_seg (
        .prot_mode (prot_mode),
        .addr      (addr),
        .seg_sel   (seg_sel),
        .lim_viol  (lim_viol),
        .verdict   (v_seg)
    );

    rfc_align_eval #(
        .ADDR_W       (ADDR_W),
        .ALIGN_LOG2   (ALIGN_LOG2),
        .AC_GRAN_LOG2 (AC_GRAN_LOG2)
    ) u_align (
        .prot_mode (prot_mode),
        .addr      (addr),
        .cpl       (cpl),
        .cr_am     (cr_am),
        .eflag_ac  (eflag_ac),
        .verdict   (v_align)
    );

    assign v_final = pick(v_early, pick(v_seg, v_align));

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_vld <= 1'b0;
            code_q    <= FLT_NONE;
        end else begin
            fault_vld <= req;
            if (req)
                code_q <= v_final.hit ? v_final.code : FLT_NONE;
        end
    end

    assign fault_code = code_q;

    // Assertions
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!fault_vld && fault_code == 3'd0));

    assert_lock_first_R2: assert property (@(posedge clk) disable iff (rst)
        (req && lock_pfx) |=> (fault_code == 3'd1));

    assert_nm_second_R3: assert property (@(posedge clk) disable iff (rst)
        (req && !lock_pfx && (cr_em || cr_ts)) |=> (fault_code == 3'd2));

    assert_stack_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !lock_pfx && !cr_em && !cr_ts && prot_mode && lim_viol && seg_sel == 3'd2)
        |=> (fault_code == 3'd4));

    assert_vld_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
        req |=> fault_vld);

    assert_no_spurious_vld_R11: assert property (@(posedge clk) disable iff (rst)
        !req |=> !fault_vld);

    assert_code_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!req && !$past(rst)) |=> $stable(fault_code));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (rst)
        fault_vld |-> (fault_code != 3'd7));
endmodule

// File: tb/restore_fault_chk_bench.sv
module restore_fault_chk_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [31:0] addr;
    logic        prot_mode;
    logic [1:0]  cpl;
    logic        cr_em, cr_ts, cr_am, eflag_ac, lock_pfx, lim_viol;
    logic [2:0]  seg_sel;
    logic        fault_vld;
    logic [2:0]  fault_code;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_code = 0;
    bit exp_vld  = 0;

    always #10 clk = ~clk;

    restore_fault_chk u_restore_fault_chk (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .prot_mode(prot_mode),
        .cpl(cpl), .cr_em(cr_em), .cr_ts(cr_ts), .cr_am(cr_am),
        .eflag_ac(eflag_ac), .lock_pfx(lock_pfx), .seg_sel(seg_sel),
        .lim_viol(lim_viol), .fault_vld(fault_vld), .fault_code(fault_code)
    );

    // Behavioural reference of the requirements
    function automatic int model();
        longint last_b;
        bit     mis, acen;
        last_b = longint'(addr) + 511;
        mis    = (addr % 16) != 0;
        acen   = cr_am && eflag_ac && (cpl == 2'd3);
        if (lock_pfx) return 1;
        if (cr_em || cr_ts) return 2;
        if (!prot_mode) begin
            if (last_b > 65535 || mis) return 6;
            return 0;
        end
        if (lim_viol) return (seg_sel == 3'd2) ? 4 : 3;
        if (mis) begin
            if (acen && (addr % 2) == 1) return 5;
            return 3;
        end
        return 0;
    endfunction

    task automatic check(string tag);
        n_tests++;
        if (fault_vld !== exp_vld || fault_code !== exp_code[2:0]) begin
            n_fail++;
            $display("FAIL %s: vld=%0b code=%0d expected vld=%0b code=%0d",
                     tag, fault_vld, fault_code, exp_vld, exp_code);
        end
    endtask

    task automatic defaults();
        addr = 32'h1000; prot_mode = 1'b1; cpl = 2'd0;
        cr_em = 0; cr_ts = 0; cr_am = 0; eflag_ac = 0;
        lock_pfx = 0; lim_viol = 0; seg_sel = 3'd3;
    endtask

    // Inputs are set at a falling edge; outputs checked at the next falling edge.
    task automatic cycle(string tag, bit r);
        req = r;
        if (r) exp_code = model();
        exp_vld = r;
        @(posedge clk);
        @(negedge clk);
        check(tag);
        req = 1'b0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; defaults();
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst = 1'b0;

        cycle("R10 clean request", 1);
        cycle("R11 idle no pulse", 0);

        defaults(); lock_pfx = 1; cr_em = 1; lim_viol = 1; addr = 32'h1001;
        cycle("R2 lock beats all", 1);
        cycle("R11 code held", 0);

        defaults(); cr_ts = 1; lim_viol = 1; seg_sel = 3'd2;
        cycle("R3 ts over limit", 1);
        defaults(); cr_em = 1; addr = 32'h1003;
        cycle("R3 em over misalign", 1);

        defaults(); lim_viol = 1; seg_sel = 3'd2; addr = 32'h1001;
        cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R4 stack limit over align", 1);
        defaults(); lim_viol = 1; seg_sel = 3'd1;
        cycle("R5 code seg limit", 1);
        defaults(); lim_viol = 1; seg_sel = 3'd5;
        cycle("R5 other seg limit", 1);

        defaults(); prot_mode = 0; addr = 32'h0000_FE00;
        cycle("R6 real last byte at limit", 1);
        defaults(); prot_mode = 0; addr = 32'h0000_FE10;
        cycle("R6 real past limit", 1);
        defaults(); prot_mode = 0; addr = 32'h0000_1008; lim_viol = 1;
        cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R6 real misaligned", 1);
        defaults(); prot_mode = 0; addr = 32'h0000_2000; lim_viol = 1; seg_sel = 3'd2;
        cycle("R6 real ignores limit flag", 1);

        defaults(); addr = 32'h1001;
        cycle("R7 odd no ac", 1);
        defaults(); addr = 32'h1008; cr_am = 1; eflag_ac = 1; cpl = 2'd2;
        cycle("R7 cpl2 no ac", 1);
        defaults(); addr = 32'h1001; cr_am = 0; eflag_ac = 1; cpl = 2'd3;
        cycle("R7 am clear", 1);
        defaults(); addr = 32'h1001; cr_am = 1; eflag_ac = 0; cpl = 2'd3;
        cycle("R7 ac flag clear", 1);

        defaults(); addr = 32'h1003; cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R8 odd with ac", 1);
        defaults(); addr = 32'h100F; cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R8 odd 15 with ac", 1);
        defaults(); addr = 32'h1002; cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R9 two-byte miss", 1);
        defaults(); addr = 32'h1008; cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R9 eight-byte miss", 1);
        cycle("R11 hold after gp", 0);
        cycle("R11 hold again", 0);

        defaults(); addr = 32'h2000; cr_am = 1; eflag_ac = 1; cpl = 2'd3;
        cycle("R10 aligned with ac", 1);

        for (int i = 0; i < 64; i++) begin
            defaults();
            addr      = 32'h0000_F000 + 32'(i * 37);
            prot_mode = i[0];
            cpl       = i[2:1];
            cr_am     = i[3];
            eflag_ac  = i[4];
            lim_viol  = (i % 7) == 0;
            seg_sel   = 3'(i % 6);
            cr_ts     = (i % 13) == 5;
            lock_pfx  = (i % 17) == 9;
            cycle("R11 mixed sweep", (i % 3) != 2);
        end

        rst = 1'b1;
        exp_vld = 0; exp_code = 0;
        @(posedge clk); @(negedge clk);
        check("R1 reset mid-run");
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule